// File: doc/BRIEF.md
# Paired-Page Translation Lookaside Buffer

This block is a fully associative translation buffer for 32-bit virtual addresses. Each entry covers an aligned 8 KB region, made of two 4 KB pages, and maps the lower (even) page and the upper (odd) page to independent physical frames. Each half has its own valid and dirty flags. An entry also carries an address-space tag and a global flag. A matching global entry is shared by every address space.

Software or a refill engine fills an entry by index through a one-cycle write port. The memory pipeline presents a lookup with a virtual address, a load/store flag and the current address-space tag. One clock later the block returns a two-bit result code, the translated physical address, and read and write permission.

Faults are split into separate codes so that the exception logic can tell three cases apart: a missing translation, an invalid page, and a store to a clean page. When several entries could match, the lowest index is used.

Top module: `ptlb_top`

## Requirements
- R1: An entry hits when its stored tag equals lookup address bits [31:13], and either its global flag is set or its stored address-space tag equals `lk_asid`.
- R2: Lookup address bit 12 picks the half of the hitting entry: 0 selects the even half and 1 selects the odd half.
- R3: If the selected half has its valid flag clear, `rsp_code` is 2'b01 (invalid). This holds for both loads and stores.
- R4: A load to a valid half, or a store to a valid half whose dirty flag is set, gives `rsp_code` 2'b00 (match). In that case `rsp_paddr` is the selected frame number in bits [31:12] and lookup address bits [11:0] in bits [11:0].
- R5: A store to a valid half whose dirty flag is clear gives `rsp_code` 2'b10 (modify fault).
- R6: If no entry hits, `rsp_code` is 2'b11 (no match).
- R7: On a match, `rsp_rd_ok` is 1 and `rsp_wr_ok` equals the selected half's dirty flag. For any other code, `rsp_rd_ok`, `rsp_wr_ok` and `rsp_paddr` are all zero.
- R8: `rsp_valid` is 1 in the cycle after a cycle with `lk_valid` high, and 0 otherwise. The response fields are registered from that lookup.
- R9: A synchronous active-low reset clears every field of every entry and clears all response outputs. After reset, therefore, a lookup in the pair at address 0 with `lk_asid` 0 returns invalid, and a lookup with any other `lk_asid` there returns no match.
- R10: An entry written at a clock edge is used by lookups presented after that edge. A lookup presented in the same cycle as a write sees the entry's previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write the entry at `wr_idx` |
| wr_idx | input | 4 | Index of the entry to fill |
| wr_vpn2 | input | 19 | Tag for the 8 KB region (address bits 31:13) |
| wr_asid | input | 8 | Address-space tag of the entry |
| wr_global | input | 1 | Entry matches any address space |
| wr_even_valid | input | 1 | Even half valid |
| wr_even_dirty | input | 1 | Even half writable |
| wr_even_frame | input | 20 | Even half physical frame number |
| wr_odd_valid | input | 1 | Odd half valid |
| wr_odd_dirty | input | 1 | Odd half writable |
| wr_odd_frame | input | 20 | Odd half physical frame number |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | 1 for a store, 0 for a load |
| lk_asid | input | 8 | Current address-space tag |
| rsp_valid | output | 1 | Response present |
| rsp_code | output | 2 | 00 match, 01 invalid, 10 modify fault, 11 no match |
| rsp_paddr | output | 32 | Physical address on match, else zero |
| rsp_rd_ok | output | 1 | Read permitted |
| rsp_wr_ok | output | 1 | Write permitted |

## Verification
A fill and a lookup can occur in the same cycle, and they can target the same entry. The bench creates this case twice by driving `wr_en` and `lk_valid` together on one entry.

In the first case, the write turns an empty slot into a hit. In the second, the write clears the even half's valid flag on a slot that already hits. Each response must reflect the entry as it was before the write: no match in the first case, and the old translation in the second. A lookup one cycle later must then reflect the new contents: a match in the first case, and invalid in the second.

// File: rtl/ptlb_pkg.sv
// Shared result encoding and the per-half access decision for the
// paired-page translation buffer.
package ptlb_pkg;

    typedef enum logic [1:0] {
        RES_MATCH   = 2'b00,
        RES_INVALID = 2'b01,
        RES_DIRTY   = 2'b10,
        RES_NOMATCH = 2'b11
    } ptlb_res_e;

    // Decide the outcome for a hitting entry's selected half.
    function automatic ptlb_res_e half_outcome(input logic valid,
                                               input logic dirty,
                                               input logic is_store);
        if (!valid)
            return RES_INVALID;
        else if (is_store && !dirty)
            return RES_DIRTY;
        else
            return RES_MATCH;
    endfunction

endpackage

// File: rtl/ptlb_store.sv
// Entry storage. Holds tag, address-space tag, global flag and two
// half-page records (valid, dirty, frame) per entry.
// Assumes: one write per cycle by index; an out-of-range index writes nothing.
module ptlb_store #(
    parameter int ENTRIES = 16,
    parameter int VPN2_W  = 19,
    parameter int ASID_W  = 8,
    parameter int FRAME_W = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [VPN2_W-1:0]  wr_vpn2,
    input  logic [ASID_W-1:0]  wr_asid,
    input  logic               wr_global,
    input  logic [1:0]         wr_valid,
    input  logic [1:0]         wr_dirty,
    input  logic [FRAME_W-1:0] wr_frame [2],
    output logic [VPN2_W-1:0]  ent_vpn2  [ENTRIES],
    output logic [ASID_W-1:0]  ent_asid  [ENTRIES],
    output logic               ent_glob  [ENTRIES],
    output logic [1:0]         ent_valid [ENTRIES],
    output logic [1:0]         ent_dirty [ENTRIES],
    output logic [FRAME_W-1:0] ent_frame [ENTRIES][2]
);

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(e));

        // Clear the entry on reset, load it when its index is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_vpn2[e]     <= '0;
                ent_asid[e]     <= '0;
                ent_glob[e]     <= 1'b0;
                ent_valid[e]    <= '0;
                ent_dirty[e]    <= '0;
                ent_frame[e][0] <= '0;
                ent_frame[e][1] <= '0;
            end else if (sel) begin
                ent_vpn2[e]     <= wr_vpn2;
                ent_asid[e]     <= wr_asid;
                ent_glob[e]     <= wr_global;
                ent_valid[e]    <= wr_valid;
                ent_dirty[e]    <= wr_dirty;
                ent_frame[e][0] <= wr_frame[0];
                ent_frame[e][1] <= wr_frame[1];
            end
        end
    end

endmodule

// File: rtl/ptlb_match.sv
// Parallel tag comparison. Flags every entry whose region tag equals the
// lookup tag and whose address space agrees (or which is global).
// Assumes: purely combinational; no priority is applied here.
module ptlb_match #(
    parameter int ENTRIES = 16,
    parameter int VPN2_W  = 19,
    parameter int ASID_W  = 8
) (
    input  logic [VPN2_W-1:0] ent_vpn2 [ENTRIES],
    input  logic [ASID_W-1:0] ent_asid [ENTRIES],
    input  logic              ent_glob [ENTRIES],
    input  logic [VPN2_W-1:0] lk_vpn2,
    input  logic [ASID_W-1:0] lk_asid,
    output logic [ENTRIES-1:0] hit_vec
);

    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        // One comparator per entry: region tag plus address-space rule.
        assign hit_vec[e] = (ent_vpn2[e] == lk_vpn2) &&
                            (ent_glob[e] || (ent_asid[e] == lk_asid));
    end

endmodule

// File: rtl/ptlb_select.sv
// Priority pick and half mux. Chooses the lowest-indexed hitting entry and
// presents the valid, dirty and frame of the half named by odd_half.
// Assumes: outputs are don't-care when any_hit is low.
module ptlb_select #(
    parameter int ENTRIES = 16,
    parameter int FRAME_W = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] hit_vec,
    input  logic               odd_half,
    input  logic [1:0]         ent_valid [ENTRIES],
    input  logic [1:0]         ent_dirty [ENTRIES],
    input  logic [FRAME_W-1:0] ent_frame [ENTRIES][2],
    output logic               any_hit,
    output logic               sel_valid,
    output logic               sel_dirty,
    output logic [FRAME_W-1:0] sel_frame
);

    logic [IDX_W-1:0] sel_idx;

    // Scan from the top down so the lowest hitting index is kept last.
    always_comb begin
        sel_idx = '0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (hit_vec[e])
                sel_idx = IDX_W'(e);
        end
    end

    assign any_hit = |hit_vec;

    // Read the chosen half of the chosen entry.
    always_comb begin
        sel_valid = ent_valid[sel_idx][odd_half];
        sel_dirty = ent_dirty[sel_idx][odd_half];
        sel_frame = ent_frame[sel_idx][odd_half];
    end

endmodule

// File: rtl/ptlb_resolve.sv
// Outcome formation. Turns the selected half and the access type into a
// result code, physical address and permissions.
// Assumes: zero address and no permission on every non-match outcome.
module ptlb_resolve #(
    parameter int PA_W      = 32,
    parameter int PAGE_BITS = 12,
    localparam int FRAME_W  = PA_W - PAGE_BITS
) (
    input  logic                 any_hit,
    input  logic                 sel_valid,
    input  logic                 sel_dirty,
    input  logic [FRAME_W-1:0]   sel_frame,
    input  logic                 is_store,
    input  logic [PAGE_BITS-1:0] page_off,
    output logic [1:0]           code,
    output logic [PA_W-1:0]      paddr,
    output logic                 rd_ok,
    output logic                 wr_ok
);

    import ptlb_pkg::*;

    ptlb_res_e res;

    // Pick the outcome: no hit first, then the half's own rules.
    always_comb begin
        if (!any_hit)
            res = RES_NOMATCH;
        else
            res = half_outcome(sel_valid, sel_dirty, is_store);
    end

    // Address and permissions only on a successful translation.
    always_comb begin
        code  = res;
        paddr = '0;
        rd_ok = 1'b0;
        wr_ok = 1'b0;
        if (res == RES_MATCH) begin
            paddr = {sel_frame, page_off};
            rd_ok = 1'b1;
            wr_ok = sel_dirty;
        end
    end

endmodule

// File: rtl/ptlb_top.sv
// Paired-page translation buffer top. Fill port writes one entry per cycle;
// lookup port answers one cycle after the request from the contents seen
// at the request's clock edge (before any same-cycle write lands).
// Assumes: 4 KB pages (PAGE_BITS), one region = two pages; synchronous
// active-low reset.
module ptlb_top #(
    parameter int ENTRIES   = 16,
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int ASID_W    = 8,
    parameter int PAGE_BITS = 12,
    localparam int IDX_W    = $clog2(ENTRIES),
    localparam int VPN2_W   = VA_W - PAGE_BITS - 1,
    localparam int FRAME_W  = PA_W - PAGE_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [VPN2_W-1:0]  wr_vpn2,
    input  logic [ASID_W-1:0]  wr_asid,
    input  logic               wr_global,
    input  logic               wr_even_valid,
    input  logic               wr_even_dirty,
    input  logic [FRAME_W-1:0] wr_even_frame,
    input  logic               wr_odd_valid,
    input  logic               wr_odd_dirty,
    input  logic [FRAME_W-1:0] wr_odd_frame,
    input  logic               lk_valid,
    input  logic [VA_W-1:0]    lk_vaddr,
    input  logic               lk_write,
    input  logic [ASID_W-1:0]  lk_asid,
    output logic               rsp_valid,
    output logic [1:0]         rsp_code,
    output logic [PA_W-1:0]    rsp_paddr,
    output logic               rsp_rd_ok,
    output logic               rsp_wr_ok
);

    logic [VPN2_W-1:0]  ent_vpn2  [ENTRIES];
    logic [ASID_W-1:0]  ent_asid  [ENTRIES];
    logic               ent_glob  [ENTRIES];
    logic [1:0]         ent_valid [ENTRIES];
    logic [1:0]         ent_dirty [ENTRIES];
    logic [FRAME_W-1:0] ent_frame [ENTRIES][2];
    logic [FRAME_W-1:0] wr_frame  [2];

    logic [ENTRIES-1:0] hit_vec;
    logic               any_hit;
    logic               sel_valid;
    logic               sel_dirty;
    logic [FRAME_W-1:0] sel_frame;
    logic [1:0]         nxt_code;
    logic [PA_W-1:0]    nxt_paddr;
    logic               nxt_rd_ok;
    logic               nxt_wr_ok;

    assign wr_frame[0] = wr_even_frame;
    assign wr_frame[1] = wr_odd_frame;

    ptlb_store #(
        .ENTRIES (ENTRIES),
        .VPN2_W  (VPN2_W),
        .ASID_W  (ASID_W),
        .FRAME_W (FRAME_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_vpn2   (wr_vpn2),
        .wr_asid   (wr_asid),
        .wr_global (wr_global),
        .wr_valid  ({wr_odd_valid, wr_even_valid}),
        .wr_dirty  ({wr_odd_dirty, wr_even_dirty}),
        .wr_frame  (wr_frame),
        .ent_vpn2  (ent_vpn2),
        .ent_asid  (ent_asid),
        .ent_glob  (ent_glob),
        .ent_valid (ent_valid),
        .ent_dirty (ent_dirty),
        .ent_frame (ent_frame)
    );

    ptlb_match #(
        .ENTRIES (ENTRIES),
        .VPN2_W  (VPN2_W),
        .ASID_W  (ASID_W)
    ) u_match (
        .ent_vpn2 (ent_vpn2),
        .ent_asid (ent_asid),
        .ent_glob (ent_glob),
        .lk_vpn2  (lk_vaddr[VA_W-1 -: VPN2_W]),
        .lk_asid  (lk_asid),
        .hit_vec  (hit_vec)
    );

    ptlb_select #(
        .ENTRIES (ENTRIES),
        .FRAME_W (FRAME_W)
    ) u_select (
        .hit_vec   (hit_vec),
        .odd_half  (lk_vaddr[PAGE_BITS]),
        .ent_valid (ent_valid),
        .ent_dirty (ent_dirty),
        .ent_frame (ent_frame),
        .any_hit   (any_hit),
        .sel_valid (sel_valid),
        .sel_dirty (sel_dirty),
        .sel_frame (sel_frame)
    );

    ptlb_resolve #(
        .PA_W      (PA_W),
        .PAGE_BITS (PAGE_BITS)
    ) u_resolve (
        .any_hit   (any_hit),
        .sel_valid (sel_valid),
        .sel_dirty (sel_dirty),
        .sel_frame (sel_frame),
        .is_store  (lk_write),
        .page_off  (lk_vaddr[PAGE_BITS-1:0]),
        .code      (nxt_code),
        .paddr     (nxt_paddr),
        .rd_ok     (nxt_rd_ok),
        .wr_ok     (nxt_wr_ok)
    );

    // Register the response of an accepted lookup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_code  <= '0;
            rsp_paddr <= '0;
            rsp_rd_ok <= 1'b0;
            rsp_wr_ok <= 1'b0;
        end else begin
            rsp_valid <= lk_valid;
            if (lk_valid) begin
                rsp_code  <= nxt_code;
                rsp_paddr <= nxt_paddr;
                rsp_rd_ok <= nxt_rd_ok;
                rsp_wr_ok <= nxt_wr_ok;
            end
        end
    end

endmodule

// File: rtl/ptlb_checker.sv
// Port-level properties of the translation buffer response, bound into
// every instance of the top module.
// Assumes: rsp_* are registered one cycle behind lk_* (checked here too).
module ptlb_checker #(
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int PAGE_BITS = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            lk_valid,
    input logic [VA_W-1:0] lk_vaddr,
    input logic            lk_write,
    input logic            rsp_valid,
    input logic [1:0]      rsp_code,
    input logic [PA_W-1:0] rsp_paddr,
    input logic            rsp_rd_ok,
    input logic            rsp_wr_ok
);

    // R8: a request is answered in the next cycle.
    p_rsp_after_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    // R8: no request, no response in the next cycle.
    p_rsp_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);

    // R4: a match keeps the page offset of the request.
    p_match_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 2'b00) |->
            rsp_paddr[PAGE_BITS-1:0] == $past(lk_vaddr[PAGE_BITS-1:0]));

    // R4: a matching store was granted write access.
    p_store_match_writable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 2'b00 && $past(lk_write)) |-> rsp_wr_ok);

    // R5: a modify fault only answers a store.
    p_dirty_only_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 2'b10) |-> $past(lk_write));

    // R7: a match always grants read.
    p_match_readable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 2'b00) |-> rsp_rd_ok);

    // R7: every fault carries no address and no permission.
    p_fault_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code != 2'b00) |->
            (!rsp_rd_ok && !rsp_wr_ok && rsp_paddr == '0));

endmodule

bind ptlb_top ptlb_checker #(
    .VA_W      (VA_W),
    .PA_W      (PA_W),
    .PAGE_BITS (PAGE_BITS)
) u_ptlb_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .lk_vaddr  (lk_vaddr),
    .lk_write  (lk_write),
    .rsp_valid (rsp_valid),
    .rsp_code  (rsp_code),
    .rsp_paddr (rsp_paddr),
    .rsp_rd_ok (rsp_rd_ok),
    .rsp_wr_ok (rsp_wr_ok)
);

// File: tb/ptlb_top_tb_top.sv
`timescale 1ns/100ps
// Bench for the paired-page translation buffer: programs three entries,
// walks a vector table, then runs directed reset and same-cycle tests.
module ptlb_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [18:0] wr_vpn2 = '0;
    logic [7:0]  wr_asid = '0;
    logic        wr_global = 1'b0;
    logic        wr_even_valid = 1'b0, wr_even_dirty = 1'b0;
    logic [19:0] wr_even_frame = '0;
    logic        wr_odd_valid = 1'b0, wr_odd_dirty = 1'b0;
    logic [19:0] wr_odd_frame = '0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_write = 1'b0;
    logic [7:0]  lk_asid = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_code;
    logic [31:0] rsp_paddr;
    logic        rsp_rd_ok, rsp_wr_ok;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ptlb_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn2(wr_vpn2), .wr_asid(wr_asid),
        .wr_global(wr_global),
        .wr_even_valid(wr_even_valid), .wr_even_dirty(wr_even_dirty),
        .wr_even_frame(wr_even_frame),
        .wr_odd_valid(wr_odd_valid), .wr_odd_dirty(wr_odd_dirty),
        .wr_odd_frame(wr_odd_frame),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_write(lk_write),
        .lk_asid(lk_asid),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_paddr(rsp_paddr),
        .rsp_rd_ok(rsp_rd_ok), .rsp_wr_ok(rsp_wr_ok)
    );

    typedef struct packed {
        logic [31:0] va;
        logic        st;
        logic [7:0]  asid;
        logic [1:0]  code;
        logic [31:0] pa;
        logic        rok;
        logic        wok;
        logic [3:0]  rq;
    } vec_t;

    // Entries: 2 = tag 0x12345 asid 0x11 (even V D 0AAAA, odd V clean 0BBBB)
    //          7 = tag 0x40000 global    (even invalid, odd V D 0CCCC)
    //         15 = tag 0x7FFFF asid 0xFF (even V clean FFFFF, odd invalid)
    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{32'h2468A123, 1'b0, 8'h11, 2'b00, 32'h0AAAA123, 1'b1, 1'b1, 4'd1}, // R1 R2 even
        '{32'h2468A123, 1'b1, 8'h11, 2'b00, 32'h0AAAA123, 1'b1, 1'b1, 4'd4}, // R4 store dirty
        '{32'h2468BABC, 1'b0, 8'h11, 2'b00, 32'h0BBBBABC, 1'b1, 1'b0, 4'd2}, // R2 odd, R7
        '{32'h2468BABC, 1'b1, 8'h11, 2'b10, 32'h0,        1'b0, 1'b0, 4'd5}, // R5
        '{32'h2468A123, 1'b0, 8'h12, 2'b11, 32'h0,        1'b0, 1'b0, 4'd1}, // R1 asid miss
        '{32'h80000456, 1'b0, 8'h55, 2'b01, 32'h0,        1'b0, 1'b0, 4'd3}, // R3 load
        '{32'h80000456, 1'b1, 8'h55, 2'b01, 32'h0,        1'b0, 1'b0, 4'd3}, // R3 store
        '{32'h80001FFF, 1'b1, 8'h00, 2'b00, 32'h0CCCCFFF, 1'b1, 1'b1, 4'd1}, // R1 global
        '{32'hFFFFE000, 1'b0, 8'hFF, 2'b00, 32'hFFFFF000, 1'b1, 1'b0, 4'd7}, // R7 clean read
        '{32'hFFFFE000, 1'b1, 8'hFF, 2'b10, 32'h0,        1'b0, 1'b0, 4'd5}, // R5
        '{32'hFFFFF000, 1'b0, 8'hFF, 2'b01, 32'h0,        1'b0, 1'b0, 4'd3}, // R3 odd
        '{32'h2468C000, 1'b0, 8'h11, 2'b11, 32'h0,        1'b0, 1'b0, 4'd6}, // R6 next pair
        '{32'h00000000, 1'b0, 8'h01, 2'b11, 32'h0,        1'b0, 1'b0, 4'd6}, // R6 R9
        '{32'h00001234, 1'b0, 8'h00, 2'b01, 32'h0,        1'b0, 1'b0, 4'd9}  // R9 reset entry
    };

    // Compare one observation and report a miscompare.
    task automatic chk(input int rq, input logic [36:0] got, input logic [36:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d got %h expected %h", rq, got, exp);
        end
    endtask

    task automatic set_write(input logic [3:0] idx, input logic [18:0] vpn2,
                             input logic [7:0] asid, input logic g,
                             input logic v0, input logic d0, input logic [19:0] f0,
                             input logic v1, input logic d1, input logic [19:0] f1);
        wr_en = 1'b1; wr_idx = idx; wr_vpn2 = vpn2; wr_asid = asid; wr_global = g;
        wr_even_valid = v0; wr_even_dirty = d0; wr_even_frame = f0;
        wr_odd_valid = v1; wr_odd_dirty = d1; wr_odd_frame = f1;
    endtask

    task automatic set_lookup(input logic [31:0] va, input logic st, input logic [7:0] asid);
        lk_valid = 1'b1; lk_vaddr = va; lk_write = st; lk_asid = asid;
    endtask

    // Let one edge pass, sample after it, and return to the falling edge idle.
    task automatic step(output logic [36:0] obs);
        @(posedge clk);
        #1;
        obs = {rsp_valid, rsp_code, rsp_paddr, rsp_rd_ok, rsp_wr_ok};
        @(negedge clk);
        wr_en = 1'b0;
        lk_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [36:0] obs;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9: response outputs cleared by reset
        chk(9, {rsp_valid, rsp_code, rsp_paddr, rsp_rd_ok, rsp_wr_ok}, 37'h0);

        set_write(4'd2, 19'h12345, 8'h11, 1'b0, 1'b1, 1'b1, 20'h0AAAA, 1'b1, 1'b0, 20'h0BBBB);
        step(obs);
        set_write(4'd7, 19'h40000, 8'h22, 1'b1, 1'b0, 1'b1, 20'h01111, 1'b1, 1'b1, 20'h0CCCC);
        step(obs);
        set_write(4'd15, 19'h7FFFF, 8'hFF, 1'b0, 1'b1, 1'b0, 20'hFFFFF, 1'b0, 1'b0, 20'h12345);
        step(obs);

        for (int i = 0; i < NV; i++) begin
            set_lookup(VECS[i].va, VECS[i].st, VECS[i].asid);
            step(obs);
            chk(int'(VECS[i].rq), obs,
                {1'b1, VECS[i].code, VECS[i].pa, VECS[i].rok, VECS[i].wok});
        end

        // R8: idle cycle after a lookup drops rsp_valid
        step(obs);
        chk(8, {36'h0, obs[36]}, 37'h0);

        // R10: same-cycle write and lookup see the old (empty) entry 4
        set_write(4'd4, 19'h00ABC, 8'h33, 1'b0, 1'b1, 1'b1, 20'h00777, 1'b0, 1'b0, 20'h0);
        set_lookup(32'h01578ABC, 1'b0, 8'h33);
        step(obs);
        chk(10, obs, {1'b1, 2'b11, 32'h0, 1'b0, 1'b0});
        // R10: the next lookup uses the new contents
        set_lookup(32'h01578ABC, 1'b1, 8'h33);
        step(obs);
        chk(10, obs, {1'b1, 2'b00, 32'h00777ABC, 1'b1, 1'b1});
        // R1: same region, other address space, non-global entry
        set_lookup(32'h01578ABC, 1'b0, 8'h34);
        step(obs);
        chk(1, obs, {1'b1, 2'b11, 32'h0, 1'b0, 1'b0});
        // R10: invalidating write in the lookup's cycle still translates
        set_write(4'd4, 19'h00ABC, 8'h33, 1'b0, 1'b0, 1'b1, 20'h00777, 1'b0, 1'b0, 20'h0);
        set_lookup(32'h01578010, 1'b0, 8'h33);
        step(obs);
        chk(10, obs, {1'b1, 2'b00, 32'h00777010, 1'b1, 1'b1});
        // R3: then the even half reads back invalid
        set_lookup(32'h01578010, 1'b0, 8'h33);
        step(obs);
        chk(3, obs, {1'b1, 2'b01, 32'h0, 1'b0, 1'b0});

        // R9: a second reset clears the programmed entries
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        set_lookup(32'h2468A123, 1'b0, 8'h11);
        step(obs);
        chk(9, obs, {1'b1, 2'b11, 32'h0, 1'b0, 1'b0});

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule